// File: doc/BRIEF.md
# Flash Erase-Verify Sequencer

This block is a host-side controller that erases a byte-wide command-register flash device and then checks every location. It drives a single-cycle memory bus (address, write data, read data, write strobe, read strobe). After a start request it writes the erase command twice. It waits for a programmable time that stands in for the erase time. It then walks the address range from zero up to a configured last address. Each location is checked in two steps: a verify command latches the address, and a read cycle returns the location's contents.

A location reads as erased when it returns FFh. If a location reads anything else, the controller issues another erase and continues from the failing address, not from zero. A programmable limit caps the number of re-erases. When every location checks clean, the controller writes the program-setup command so the device leaves verify mode, and it pulses done. When the re-erase limit is used up, it writes the reset command, sets error and pulses done. The last address, retry limit and wait time are captured when a start is accepted.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, busy_o, done_o, error_o, bus_we_o and bus_re_o are all low.
- R2: An accepted start_i in idle begins with two write cycles on consecutive clocks, both with data 20h. The address on these writes is 0.
- R3: The first verify command follows the second erase write by exactly erase_wait_i + 2 clock cycles.
- R4: Each read strobe comes in the cycle right after a write of A0h to the same address. The read data is sampled in the cycle after the read strobe.
- R5: Verification visits addresses 0 up to last_addr_i in ascending order, one verify command per address, as long as every location reads FFh.
- R6: A verify read other than FFh causes a new two-write erase. After the erase wait, verification resumes at the failing address, and addresses already checked are not revisited.
- R7: At most max_retry_i re-erases are issued. A failing read after that count causes a write of FFh, then error_o goes high and the controller stops. error_o stays high until the next accepted start.
- R8: After the last address reads FFh, the controller writes 40h. done_o is then high for exactly one cycle and error_o stays low.
- R9: busy_o is high from the cycle after an accepted start until the final command write. A start_i raised while busy is ignored, and no strobe occurs while idle.
- R10: The write strobe and the read strobe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request; acted on only in idle |
| last_addr_i | input | ADDR_W | Highest address to verify |
| max_retry_i | input | RETRY_W | Re-erase limit |
| erase_wait_i | input | WAIT_W | Cycles of erase wait, minus one |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| error_o | output | 1 | Retry limit exceeded |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | 8 | Bus write data |
| bus_we_o | output | 1 | Write strobe, one cycle per access |
| bus_re_o | output | 1 | Read strobe, one cycle per access |
| bus_rdata_i | input | 8 | Read data, valid the cycle after bus_re_o |

## Verification
The bench uses a flash model in which each location turns erased only after a set number of erase operations. In this model a design that restarts from zero after a re-erase shows extra verifies at address 0. A design that never re-erases ends with the wrong verify count. The bench runs out the retry limit, including a limit of zero, and checks that the reset command and the error flag appear after exactly the allowed number of erases; an off-by-one counter gives one erase too many or too few. It also measures the erase-to-verify gap for a zero and a non-zero wait, runs a single-location range, and checks that a read uses the address latched by its verify command. A stray start during a run must not add an erase.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_ERASE  = 8'h20;
  localparam logic [BYTE_W-1:0] CMD_VERIFY = 8'hA0;
  localparam logic [BYTE_W-1:0] CMD_PGM    = 8'h40;
  localparam logic [BYTE_W-1:0] CMD_RESET  = 8'hFF;
  localparam logic [BYTE_W-1:0] VAL_BLANK  = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ERA1,
    ST_ERA2,
    ST_WAIT,
    ST_VCMD,
    ST_VRD,
    ST_VCHK,
    ST_EXIT,
    ST_ABORT
  } fes_state_e;
endpackage

// File: rtl/fes_wait_timer.sv
module fes_wait_timer #(
  parameter int unsigned WAIT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] val_i,
  output logic              zero_o
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fes_retry_ctr.sv
module fes_retry_ctr #(
  parameter int unsigned RETRY_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               inc_i,
  input  logic [RETRY_W-1:0] limit_i,
  output logic               spent_o
);
  logic [RETRY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign spent_o = (cnt_q == limit_i);
endmodule

// File: rtl/fes_addr_walk.sv
module fes_addr_walk #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  input  logic [ADDR_W-1:0] last_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              at_last_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (clr_i)   addr_q <= '0;
    else if (inc_i)   addr_q <= addr_q + 1'b1;
  end

  assign addr_o    = addr_q;
  assign at_last_o = (addr_q == last_i);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned RETRY_W = 4,
  parameter int unsigned WAIT_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  last_addr_i,
  input  logic [RETRY_W-1:0] max_retry_i,
  input  logic [WAIT_W-1:0]  erase_wait_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               error_o,
  output logic [ADDR_W-1:0]  bus_addr_o,
  output logic [BYTE_W-1:0]  bus_wdata_o,
  output logic               bus_we_o,
  output logic               bus_re_o,
  input  logic [BYTE_W-1:0]  bus_rdata_i
);
  fes_state_e state_q, state_d;

  logic [ADDR_W-1:0]  last_q;
  logic [RETRY_W-1:0] retry_q;
  logic [WAIT_W-1:0]  wait_q;
  logic               done_q, error_q;

  logic accept, blank;
  logic tmr_zero, retry_spent, at_last;
  logic addr_inc, retry_inc;
  logic [ADDR_W-1:0] cur_addr;

  assign accept = (state_q == ST_IDLE) && start_i;
  assign blank  = (bus_rdata_i == VAL_BLANK);

  // configuration captured once per run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q  <= '0;
      retry_q <= '0;
      wait_q  <= '0;
    end else if (accept) begin
      last_q  <= last_addr_i;
      retry_q <= max_retry_i;
      wait_q  <= erase_wait_i;
    end
  end

  fes_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_q == ST_ERA2),
    .val_i  (wait_q),
    .zero_o (tmr_zero)
  );

  fes_retry_ctr #(.RETRY_W(RETRY_W)) u_retry (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .inc_i   (retry_inc),
    .limit_i (retry_q),
    .spent_o (retry_spent)
  );

  fes_addr_walk #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (accept),
    .inc_i     (addr_inc),
    .last_i    (last_q),
    .addr_o    (cur_addr),
    .at_last_o (at_last)
  );

  always_comb begin
    state_d   = state_q;
    addr_inc  = 1'b0;
    retry_inc = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_ERA1;
      ST_ERA1:  state_d = ST_ERA2;
      ST_ERA2:  state_d = ST_WAIT;
      ST_WAIT:  if (tmr_zero) state_d = ST_VCMD;
      ST_VCMD:  state_d = ST_VRD;
      ST_VRD:   state_d = ST_VCHK;
      ST_VCHK: begin
        if (blank) begin
          if (at_last) state_d = ST_EXIT;
          else begin
            state_d  = ST_VCMD;
            addr_inc = 1'b1;
          end
        end else if (retry_spent) begin
          state_d = ST_ABORT;
        end else begin
          // re-erase; address counter holds the failing location
          state_d   = ST_ERA1;
          retry_inc = 1'b1;
        end
      end
      ST_EXIT:  state_d = ST_IDLE;
      ST_ABORT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      error_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_EXIT) || (state_q == ST_ABORT);
      if (accept)                     error_q <= 1'b0;
      else if (state_q == ST_ABORT)   error_q <= 1'b1;
    end
  end

  always_comb begin
    bus_we_o    = 1'b0;
    bus_re_o    = 1'b0;
    bus_wdata_o = '0;
    bus_addr_o  = '0;
    unique case (state_q)
      ST_ERA1, ST_ERA2: begin
        bus_we_o    = 1'b1;
        bus_wdata_o = CMD_ERASE;
      end
      ST_VCMD: begin
        bus_we_o    = 1'b1;
        bus_wdata_o = CMD_VERIFY;
        bus_addr_o  = cur_addr;
      end
      ST_VRD: begin
        bus_re_o   = 1'b1;
        bus_addr_o = cur_addr;
      end
      ST_EXIT: begin
        bus_we_o    = 1'b1;
        bus_wdata_o = CMD_PGM;
      end
      ST_ABORT: begin
        bus_we_o    = 1'b1;
        bus_wdata_o = CMD_RESET;
      end
      default: ;
    endcase
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign error_o = error_q;
endmodule

// File: rtl/fes_checker.sv
module fes_checker
  import fes_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              error_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [BYTE_W-1:0] bus_wdata_o,
  input logic              bus_we_o,
  input logic              bus_re_o
);
  p_one_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_o && bus_re_o));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_read_after_vcmd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_re_o |-> ($past(bus_we_o) && $past(bus_wdata_o) == CMD_VERIFY
                  && $past(bus_addr_o) == bus_addr_o));

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!bus_we_o && !bus_re_o));

  p_error_ends_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> done_o);

  p_reset_cmd_before_error_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> ($past(bus_we_o) && $past(bus_wdata_o) == CMD_RESET));

  p_erase_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && bus_wdata_o == CMD_ERASE && $past(!busy_o || bus_re_o || bus_we_o == 1'b0))
    |=> (bus_we_o && bus_wdata_o == CMD_ERASE));
endmodule

bind flash_erase_seq fes_checker #(.ADDR_W(ADDR_W)) u_fes_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .error_o     (error_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_we_o    (bus_we_o),
  .bus_re_o    (bus_re_o)
);

// File: tb/test_flash_erase_seq.sv
module test_flash_erase_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] last_addr_i = '0;
  logic [3:0] max_retry_i = '0;
  logic [15:0] erase_wait_i = '0;
  logic       busy_o, done_o, error_o;
  logic [7:0] bus_addr_o, bus_wdata_o, bus_rdata_i;
  logic       bus_we_o, bus_re_o;

  int total = 0;
  int bad   = 0;

  flash_erase_seq i_flash_erase_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .last_addr_i  (last_addr_i),
    .max_retry_i  (max_retry_i),
    .erase_wait_i (erase_wait_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .error_o      (error_o),
    .bus_addr_o   (bus_addr_o),
    .bus_wdata_o  (bus_wdata_o),
    .bus_we_o     (bus_we_o),
    .bus_re_o     (bus_re_o),
    .bus_rdata_i  (bus_rdata_i)
  );

  always #5 clk_i = ~clk_i;

  // flash model: a location reads FFh once enough erases have happened
  int need [256];
  int vper [256];
  int cyc = 0, erases = 0, vcnt = 0, proto_err = 0, era_addr_err = 0;
  int era_end = 0, gap = -1, resume = -1;
  bit half = 0, pend_gap = 0, pend_res = 0, prev_vcmd = 0;
  logic [7:0] latched = '0, last_cmd = '0;

  initial bus_rdata_i = '0;

  always @(posedge clk_i) begin
    cyc = cyc + 1;
    if (bus_re_o) begin
      if (!prev_vcmd || bus_addr_o != latched) proto_err = proto_err + 1;
      bus_rdata_i <= (erases >= need[latched]) ? 8'hFF : 8'h00;
    end
    if (bus_we_o) begin
      last_cmd = bus_wdata_o;
      if (bus_wdata_o == 8'h20) begin
        if (bus_addr_o != 0) era_addr_err = era_addr_err + 1;
        if (half) begin
          erases = erases + 1; half = 0; era_end = cyc;
          pend_gap = 1; pend_res = (erases > 1);
        end else half = 1;
      end else half = 0;
      if (bus_wdata_o == 8'hA0) begin
        latched = bus_addr_o;
        vcnt = vcnt + 1;
        vper[bus_addr_o] = vper[bus_addr_o] + 1;
        if (pend_gap) gap = cyc - era_end;
        if (pend_res && resume < 0) resume = bus_addr_o;
        pend_gap = 0; pend_res = 0;
      end
    end else half = 0;
    prev_vcmd = bus_we_o && bus_wdata_o == 8'hA0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear(input int default_need);
    for (int i = 0; i < 256; i++) begin
      need[i] = default_need;
      vper[i] = 0;
    end
    erases = 0; vcnt = 0; proto_err = 0; era_addr_err = 0;
    gap = -1; resume = -1; half = 0; pend_gap = 0; pend_res = 0;
    last_cmd = '0;
  endtask

  // start a run and wait for done; returns 1 when done seen
  task automatic run(input int last, input int retry, input int wt,
                     input bit poke, output bit seen);
    @(negedge clk_i);
    last_addr_i = last[7:0]; max_retry_i = retry[3:0]; erase_wait_i = wt[15:0];
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    last_addr_i = 8'hEE; max_retry_i = 4'hF; erase_wait_i = 16'd3;
    seen = 0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      if (poke && i == 20) start_i = 1'b1;
      else start_i = 1'b0;
      if (done_o) seen = 1;
      else @(negedge clk_i);
    end
    start_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(!busy_o, "R1 busy", busy_o, 0);
    chk(!done_o, "R1 done", done_o, 0);
    chk(!error_o, "R1 error", error_o, 0);
    chk(!bus_we_o && !bus_re_o, "R1 strobes", bus_we_o | bus_re_o, 0);
  endtask

  task automatic t_clean();
    bit seen;
    model_clear(1);
    run(15, 3, 2, 1'b1, seen);
    chk(seen, "R8 done seen", seen, 1);
    chk(!error_o, "R8 no error", error_o, 0);
    chk(!busy_o, "R9 idle at done", busy_o, 0);
    chk(last_cmd == 8'h40, "R8 exit cmd", last_cmd, 8'h40);
    chk(erases == 1, "R9 stray start ignored / R2 erase", erases, 1);
    chk(vcnt == 16, "R5 verify count", vcnt, 16);
    chk(vper[0] == 1 && vper[15] == 1 && vper[16] == 0, "R5 range", vper[16], 0);
    chk(proto_err == 0, "R4 read after verify", proto_err, 0);
    chk(era_addr_err == 0, "R2 erase address zero", era_addr_err, 0);
    @(negedge clk_i);
    chk(!done_o, "R8 done one cycle", done_o, 0);
  endtask

  task automatic t_resume();
    bit seen;
    model_clear(1);
    need[5] = 2;
    run(15, 3, 1, 1'b0, seen);
    chk(seen && !error_o, "R6 success after re-erase", error_o, 0);
    chk(erases == 2, "R6 erase count", erases, 2);
    chk(resume == 5, "R6 resume address", resume, 5);
    chk(vper[0] == 1, "R6 no restart from zero", vper[0], 1);
    chk(vcnt == 17, "R6 verify count", vcnt, 17);
    chk(proto_err == 0, "R4 latched address", proto_err, 0);
  endtask

  task automatic t_exhaust();
    bit seen;
    model_clear(1);
    need[3] = 5;
    run(15, 2, 0, 1'b0, seen);
    chk(seen, "R7 done on abort", seen, 1);
    chk(error_o, "R7 error set", error_o, 1);
    chk(erases == 3, "R7 erase count", erases, 3);
    chk(vcnt == 6, "R7 verify count", vcnt, 6);
    chk(last_cmd == 8'hFF, "R7 reset cmd", last_cmd, 8'hFF);
    repeat (3) @(negedge clk_i);
    chk(error_o && !busy_o, "R7 error held", error_o, 1);
    // zero limit: first failure aborts
    model_clear(1);
    need[0] = 2;
    run(3, 0, 0, 1'b0, seen);
    chk(error_o && erases == 1, "R7 zero limit", erases, 1);
  endtask

  task automatic t_wait();
    bit seen;
    model_clear(1);
    run(2, 1, 7, 1'b0, seen);
    chk(gap == 9, "R3 gap wait=7", gap, 9);
    chk(!error_o, "R7 error cleared on start", error_o, 0);
    model_clear(1);
    run(2, 1, 0, 1'b0, seen);
    chk(gap == 2, "R3 gap wait=0", gap, 2);
  endtask

  task automatic t_single();
    bit seen;
    model_clear(1);
    run(0, 1, 1, 1'b0, seen);
    chk(seen && vcnt == 1, "R5 single location", vcnt, 1);
    chk(last_cmd == 8'h40, "R8 exit cmd single", last_cmd, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_clean();
    t_resume();
    t_exhaust();
    t_wait();
    t_single();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    total = total + 1;
    bad = bad + 1;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule